// File: doc/BRIEF.md
# DMA Start Trigger and Channel Arbiter

This block sits beside a four-channel memory transfer engine. It decides when each channel has work waiting and which waiting channel owns the bus. Each channel has a start-timing code. A channel waits for its trigger: its own enable edge, a vertical-blank or horizontal-blank strobe, or a channel-specific special source. Once triggered, the channel becomes pending and is given a fixed start latency before its first unit may run.

The arbiter picks one pending channel at a time. It issues a one-cycle start grant to the transfer engine and then holds that channel as the owner until the engine reports the end of the unit. It picks again after every unit, so a more urgent channel can take over between two units of a long block. While any transfer is in progress the CPU is stalled. The stall is released once no channel is pending.

Each channel runs a small state machine. CH_IDLE goes to CH_ARMED when a trigger is accepted. CH_ARMED goes to CH_ACTIVE when the channel receives its first grant. Both CH_ARMED and CH_ACTIVE return to CH_IDLE when the block is retired or the enable drops. The arbiter state machine also has three states. ARB_IDLE (nothing pending) moves to ARB_WAIT when a channel becomes pending. ARB_IDLE or ARB_WAIT moves to ARB_BUSY on a start grant. ARB_BUSY returns to ARB_WAIT or ARB_IDLE on unit done, depending on whether pending channels remain.

Top module: `xfer_trigger_arbiter`

## Requirements
- R1: After reset, active_valid, start_grant and cpu_stall are low and active_ch is 0.
- R2: Timing code 0 (bits 2i+1:2i of chan_mode for channel i) arms channel i when its enable is first sampled high. start_grant for it is high in the cycle that begins 3 clock edges after that sampling edge.
- R3: Timing code 1 arms channels on vblank_stb and code 2 arms them on hblank_stb. Only enabled channels of the matching code that are not already pending are armed. Their grant follows 3 edges after the strobe's sampling edge.
- R4: Timing code 3 never arms channel 0. With code 3, channel 1 is armed by fifo_req[0], channel 2 by fifo_req[1] and channel 3 by disp_start_stb.
- R5: Among pending channels, the lowest-numbered one is taken first. A higher-numbered channel replaces it only if that channel has not yet been granted and has strictly fewer cycles left to wait.
- R6: start_grant is a single-cycle pulse, raised only when the selected channel's wait has expired and no unit is in flight. active_ch then holds until unit_done. unit_done together with block_done retires that channel.
- R7: cpu_stall rises in the cycle after a start grant. It stays high until the first cycle after one in which no channel is pending.
- R8: A trigger that arrives while its channel is already pending is ignored. When that channel's block completes, no extra grant follows.
- R9: The owner is chosen again after each unit. A lower-numbered channel that became pending during a long block takes the bus before the long block resumes.
- R10: If a trigger for a channel arrives in the same cycle as that channel's block completion, the trigger is ignored and the channel ends idle.
- R11: Driving a channel's enable low clears its pending state, so it receives no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 4 | Per-channel enable |
| chan_mode | input | 8 | Per-channel 2-bit timing code, channel i at bits 2i+1:2i |
| hblank_stb | input | 1 | Horizontal-blank strobe |
| vblank_stb | input | 1 | Vertical-blank strobe |
| disp_start_stb | input | 1 | Display-start strobe (channel 3 special source) |
| fifo_req | input | 2 | Audio FIFO request pulses for channels 1 and 2 |
| unit_done | input | 1 | Transfer engine finished the current unit |
| block_done | input | 1 | With unit_done: the unit was the block's last |
| active_valid | output | 1 | A channel is selected or owns the bus |
| active_ch | output | 2 | Selected or owning channel |
| start_grant | output | 1 | One-cycle start pulse for active_ch |
| cpu_stall | output | 1 | CPU hold request |

## Verification
Block completion and a new trigger for the same channel can land in one cycle. A channel arming and another channel's completion can also coincide. The bench provokes the first case by driving unit_done, block_done and the matching blank strobe together, and then confirms that no further grant appears. A behavioural reference model of per-channel pending, wait and started state is compared with every output on every clock. Directed checks also measure grant latency and takeover order.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [1:0] {
        TM_NOW     = 2'd0,
        TM_VBLANK  = 2'd1,
        TM_HBLANK  = 2'd2,
        TM_SPECIAL = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ARMED  = 2'd1,
        CH_ACTIVE = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_WAIT = 2'd1,
        ARB_BUSY = 2'd2
    } arb_state_e;
endpackage

// File: rtl/chan_trigger.sv
module chan_trigger
    import dma_arb_pkg::*;
#(
    parameter int START_LAT = 3,
    parameter int WW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    mode,
    input  logic          hblank,
    input  logic          vblank,
    input  logic          special,
    input  logic          grant_me,
    input  logic          retire_me,
    output logic          pending,
    output logic          started,
    output logic [WW-1:0] wait_left
);
    localparam logic [WW-1:0] LAT_V = WW'(START_LAT);

    ch_state_e     st;
    logic [WW-1:0] wait_q;
    logic          en_q;
    logic          trig;

    // trigger source chosen by the timing code
    always_comb begin
        unique case (trig_mode_e'(mode))
            TM_NOW:     trig = en && !en_q;
            TM_VBLANK:  trig = vblank;
            TM_HBLANK:  trig = hblank;
            TM_SPECIAL: trig = special;
            default:    trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= CH_IDLE;
            wait_q <= '0;
            en_q   <= 1'b0;
        end else begin
            en_q <= en;
            if (st != CH_IDLE && wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
            end
            if (!en || retire_me) begin
                st <= CH_IDLE;
            end else begin
                unique case (st)
                    CH_IDLE: begin
                        if (trig) begin
                            st     <= CH_ARMED;
                            wait_q <= LAT_V;
                        end
                    end
                    CH_ARMED: begin
                        if (grant_me) begin
                            st <= CH_ACTIVE;
                        end
                    end
                    CH_ACTIVE: st <= CH_ACTIVE;
                    default:   st <= CH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        pending   = (st != CH_IDLE);
        started   = (st == CH_ACTIVE);
        wait_left = wait_q;
    end

    // R6: the arbiter only starts a channel that is pending and due
    a_r6_grant_due: assert property (@(posedge clk) disable iff (!rst_n)
        grant_me |-> (st != CH_IDLE && wait_q == '0));

    // R11: a dropped enable leaves the channel idle
    a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == CH_IDLE));
endmodule

// File: rtl/chan_select.sv
module chan_select #(
    parameter int NUM_CH = 4,
    parameter int WW     = 2,
    parameter int IW     = 2
) (
    input  logic [NUM_CH-1:0]    pend,
    input  logic [NUM_CH-1:0]    started,
    input  logic [NUM_CH*WW-1:0] wait_flat,
    output logic                 sel_valid,
    output logic [IW-1:0]        sel_idx,
    output logic [WW-1:0]        sel_wait
);
    // lowest index first; a later unstarted channel wins only if due sooner
    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        sel_wait  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pend[i]) begin
                if (!sel_valid) begin
                    sel_valid = 1'b1;
                    sel_idx   = IW'(i);
                    sel_wait  = wait_flat[i*WW +: WW];
                end else if (!started[i] && wait_flat[i*WW +: WW] < sel_wait) begin
                    sel_idx  = IW'(i);
                    sel_wait = wait_flat[i*WW +: WW];
                end
            end
        end
    end
endmodule

// File: rtl/xfer_trigger_arbiter.sv
module xfer_trigger_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int START_LAT = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         chan_en,
    input  logic [2*NUM_CH-1:0]       chan_mode,
    input  logic                      hblank_stb,
    input  logic                      vblank_stb,
    input  logic                      disp_start_stb,
    input  logic [NUM_CH-3:0]         fifo_req,
    input  logic                      unit_done,
    input  logic                      block_done,
    output logic                      active_valid,
    output logic [$clog2(NUM_CH)-1:0] active_ch,
    output logic                      start_grant,
    output logic                      cpu_stall
);
    localparam int IW    = $clog2(NUM_CH);
    localparam int WW    = $clog2(START_LAT + 1);
    localparam int NFIFO = NUM_CH - 2;

    arb_state_e         st, st_nx;
    logic [IW-1:0]      busy_ch;
    logic [NUM_CH-1:0]  pend_vec, start_vec, grant_vec, retire_vec;
    logic [NUM_CH*WW-1:0] wait_flat;
    logic               sel_valid;
    logic [IW-1:0]      sel_idx;
    logic [WW-1:0]      sel_wait;
    logic               retire_now;

    assign retire_now = (st == ARB_BUSY) && unit_done && block_done;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic special_src;
        if (i == 0) begin : g_none
            assign special_src = 1'b0;
        end else if (i <= NFIFO) begin : g_fifo
            assign special_src = fifo_req[i-1];
        end else begin : g_disp
            assign special_src = disp_start_stb;
        end

        assign grant_vec[i]  = start_grant && (sel_idx == IW'(i));
        assign retire_vec[i] = retire_now && (busy_ch == IW'(i));

        chan_trigger #(.START_LAT(START_LAT), .WW(WW)) u_trig (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (chan_en[i]),
            .mode      (chan_mode[2*i +: 2]),
            .hblank    (hblank_stb),
            .vblank    (vblank_stb),
            .special   (special_src),
            .grant_me  (grant_vec[i]),
            .retire_me (retire_vec[i]),
            .pending   (pend_vec[i]),
            .started   (start_vec[i]),
            .wait_left (wait_flat[i*WW +: WW])
        );
    end

    chan_select #(.NUM_CH(NUM_CH), .WW(WW), .IW(IW)) u_sel (
        .pend      (pend_vec),
        .started   (start_vec),
        .wait_flat (wait_flat),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx),
        .sel_wait  (sel_wait)
    );

    assign start_grant = (st != ARB_BUSY) && sel_valid && (sel_wait == '0);

    always_comb begin
        st_nx = st;
        unique case (st)
            ARB_IDLE, ARB_WAIT: begin
                if (start_grant)        st_nx = ARB_BUSY;
                else if (|pend_vec)     st_nx = ARB_WAIT;
                else                    st_nx = ARB_IDLE;
            end
            ARB_BUSY: begin
                if (unit_done) begin
                    st_nx = (|(pend_vec & ~retire_vec)) ? ARB_WAIT : ARB_IDLE;
                end
            end
            default: st_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ARB_IDLE;
            busy_ch   <= '0;
            cpu_stall <= 1'b0;
        end else begin
            st <= st_nx;
            if (start_grant) begin
                busy_ch   <= sel_idx;
                cpu_stall <= 1'b1;
            end else if (pend_vec == '0) begin
                cpu_stall <= 1'b0;
            end
        end
    end

    always_comb begin
        active_valid = (st == ARB_BUSY) || sel_valid;
        active_ch    = (st == ARB_BUSY) ? busy_ch : sel_idx;
    end

    // R7: stall follows a grant
    a_r7_stall_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant |=> cpu_stall);

    // R7: stall drops once nothing is pending
    a_r7_stall_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec == '0 && !start_grant) |=> !cpu_stall);

    // R6: owner is held while a unit is in flight
    a_r6_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ARB_BUSY && !unit_done) |=> (active_ch == $past(active_ch)));

    // R5: the granted channel is one the channels report as pending
    a_r5_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant |-> pend_vec[sel_idx]);
endmodule

// File: tb/xfer_trigger_arbiter_test.sv
module xfer_trigger_arbiter_test;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] en_r = '0;
    logic [7:0] mode_r = '0;
    logic       hblank = 1'b0, vblank = 1'b0, disp = 1'b0;
    logic [1:0] fifo = '0;
    logic       unit_done = 1'b0, block_done = 1'b0;
    logic       active_valid, start_grant, cpu_stall;
    logic [1:0] active_ch;

    always #5 clk = ~clk;

    xfer_trigger_arbiter uut (
        .clk(clk), .rst_n(rst_n), .chan_en(en_r), .chan_mode(mode_r),
        .hblank_stb(hblank), .vblank_stb(vblank), .disp_start_stb(disp),
        .fifo_req(fifo), .unit_done(unit_done), .block_done(block_done),
        .active_valid(active_valid), .active_ch(active_ch),
        .start_grant(start_grant), .cpu_stall(cpu_stall)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_pend[4], m_start[4], m_wait[4], m_enq[4];
    int m_busy, m_bch, m_stall;

    function automatic int pick();
        int b;
        b = -1;
        for (int i = 0; i < 4; i++) begin
            if (m_pend[i] != 0) begin
                if (b < 0) b = i;
                else if (m_start[i] == 0 && m_wait[i] < m_wait[b]) b = i;
            end
        end
        return b;
    endfunction

    function automatic bit spec_src(int i);
        if (i == 1) return fifo[0];
        if (i == 2) return fifo[1];
        if (i == 3) return disp;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        int b, r, md;
        bit g, anyp, t;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_pend[i] = 0; m_start[i] = 0; m_wait[i] = 0; m_enq[i] = 0;
            end
            m_busy = 0; m_bch = 0; m_stall = 0;
        end else begin
            b = pick();
            g = (m_busy == 0 && b >= 0 && m_wait[b] == 0);
            anyp = 0;
            for (int i = 0; i < 4; i++) if (m_pend[i] != 0) anyp = 1;
            r = (m_busy != 0 && unit_done && block_done) ? m_bch : -1;
            for (int i = 0; i < 4; i++) begin
                md = int'(mode_r[2*i +: 2]);
                if (md == 0)      t = en_r[i] && (m_enq[i] == 0);
                else if (md == 1) t = vblank;
                else if (md == 2) t = hblank;
                else              t = spec_src(i);
                if (m_pend[i] != 0 && m_wait[i] > 0) m_wait[i]--;
                if (!en_r[i] || r == i) begin
                    m_pend[i] = 0; m_start[i] = 0;
                end else if (m_pend[i] == 0) begin
                    if (t) begin m_pend[i] = 1; m_wait[i] = LAT; m_start[i] = 0; end
                end else if (g && b == i) begin
                    m_start[i] = 1;
                end
                m_enq[i] = en_r[i];
            end
            if (g) m_stall = 1;
            else if (!anyp) m_stall = 0;
            if (g) begin m_busy = 1; m_bch = b; end
            else if (m_busy != 0 && unit_done) m_busy = 0;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int b, ev, ec, eg;
        b  = pick();
        ev = (m_busy != 0 || b >= 0) ? 1 : 0;
        ec = (m_busy != 0) ? m_bch : (b < 0 ? 0 : b);
        eg = (m_busy == 0 && b >= 0 && m_wait[b] == 0) ? 1 : 0;
        check(active_valid == ev[0] && active_ch == ec[1:0] && start_grant == eg[0]
              && cpu_stall == m_stall[0], cur_req, "outputs {valid,ch,grant,stall}",
              {active_valid, active_ch, start_grant, cpu_stall},
              {ev[0], ec[1:0], eg[0], m_stall[0]});
    endtask

    // bench-side transfer engine
    bit auto_eng = 1;
    int units[4];
    int eng_t = 0, eng_ch = 0;
    bit s_grant, s_valid, s_stall;
    logic [1:0] s_ch;

    task automatic step();
        @(negedge clk);
        compare();
        s_grant = start_grant; s_ch = active_ch; s_valid = active_valid; s_stall = cpu_stall;
        hblank = 0; vblank = 0; disp = 0; fifo = '0; unit_done = 0; block_done = 0;
        if (auto_eng) begin
            if (eng_t > 0) begin
                eng_t--;
                if (eng_t == 0) begin
                    unit_done  = 1;
                    block_done = (units[eng_ch] <= 1);
                    units[eng_ch]--;
                end
            end
            if (s_grant) begin eng_t = 2; eng_ch = int'(s_ch); end
        end
    endtask

    task automatic wait_grant(output int n);
        n = 0;
        do begin step(); n++; end while (!s_grant && n < 40);
    endtask

    task automatic run_idle();
        int k;
        k = 0;
        do begin step(); k++; end while ((s_valid || s_stall || eng_t != 0) && k < 80);
    endtask

    task automatic quiet(int n, string req);
        bit any;
        any = 0;
        for (int k = 0; k < n; k++) begin step(); if (s_valid || s_grant) any = 1; end
        check(!any, req, "no activity in window", any, 0);
    endtask

    task automatic set_mode(int ch, int m);
        mode_r[2*ch +: 2] = m[1:0];
    endtask

    task automatic clear_all();
        en_r = '0; step(); step();
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        step();
        check(!active_valid && !start_grant && !cpu_stall && active_ch == 0, "R1", "reset outputs",
              {active_valid, start_grant, cpu_stall}, 0);

        // R2 immediate start, 3-edge latency
        cur_req = "R2";
        units[0] = 2; set_mode(0, 0); en_r[0] = 1;
        wait_grant(n);
        check(n - 1 == LAT, "R2", "edges to grant", n - 1, LAT);
        check(s_ch == 0, "R2", "granted channel", s_ch, 0);
        step();
        check(s_stall, "R7", "stall after grant", s_stall, 1);
        run_idle();
        check(!s_stall, "R7", "stall released when idle", s_stall, 0);
        clear_all();

        // R3 blank strobes select by code
        cur_req = "R3";
        set_mode(1, 2); set_mode(2, 1); units[1] = 1; units[2] = 1; en_r = 4'b0110;
        step();
        hblank = 1;
        wait_grant(n);
        check(n - 1 == LAT && s_ch == 1, "R3", "hblank grant edge/ch", n - 1, LAT);
        run_idle();
        vblank = 1;
        wait_grant(n);
        check(s_ch == 2, "R3", "vblank granted channel", s_ch, 2);
        run_idle();
        clear_all();

        // R4 special sources
        cur_req = "R4";
        set_mode(0, 3); en_r = 4'b0001; step();
        fifo = 2'b11; disp = 1; step();
        hblank = 1; vblank = 1;
        quiet(8, "R4");
        set_mode(1, 3); set_mode(2, 3); set_mode(3, 3); en_r = 4'b1110;
        units[1] = 1; units[2] = 1; units[3] = 1; step();
        fifo = 2'b01; wait_grant(n);
        check(s_ch == 1, "R4", "fifo0 -> channel", s_ch, 1);
        run_idle();
        fifo = 2'b10; wait_grant(n);
        check(s_ch == 2, "R4", "fifo1 -> channel", s_ch, 2);
        run_idle();
        disp = 1; wait_grant(n);
        check(s_ch == 3, "R4", "display start -> channel", s_ch, 3);
        run_idle();
        clear_all();

        // R5 lowest first, then earlier-due preemption
        cur_req = "R5";
        set_mode(1, 2); set_mode(3, 2); units[1] = 1; units[3] = 1; en_r = 4'b1010; step();
        hblank = 1; wait_grant(n);
        check(s_ch == 1, "R5", "lowest pending first", s_ch, 1);
        wait_grant(n);
        check(s_ch == 3, "R5", "next pending after", s_ch, 3);
        run_idle();
        clear_all();
        set_mode(2, 1); set_mode(0, 0); units[2] = 1; units[0] = 1; en_r = 4'b0100; step();
        vblank = 1; step(); step();
        en_r[0] = 1;
        wait_grant(n);
        check(s_ch == 2, "R5", "earlier-due higher channel preempts", s_ch, 2);
        wait_grant(n);
        check(s_ch == 0, "R5", "lower channel follows", s_ch, 0);
        run_idle();
        clear_all();

        // R8 duplicate trigger ignored
        cur_req = "R8";
        set_mode(1, 3); units[1] = 1; en_r = 4'b0010; step();
        fifo = 2'b01; step();
        fifo = 2'b01; step();
        wait_grant(n);
        check(s_ch == 1, "R8", "first request granted", s_ch, 1);
        run_idle();
        quiet(8, "R8");
        clear_all();

        // R9 lower channel takes over between units
        cur_req = "R9";
        set_mode(3, 0); set_mode(0, 0); units[3] = 3; units[0] = 1; en_r = 4'b1000;
        wait_grant(n);
        check(s_ch == 3, "R9", "long block starts", s_ch, 3);
        en_r[0] = 1;
        wait_grant(n);
        check(s_ch == 0, "R9", "takeover between units", s_ch, 0);
        wait_grant(n);
        check(s_ch == 3, "R9", "long block resumes", s_ch, 3);
        run_idle();
        clear_all();

        // R10 completion and re-trigger in the same cycle
        cur_req = "R10";
        auto_eng = 0;
        set_mode(2, 2); en_r = 4'b0100; step();
        hblank = 1; wait_grant(n);
        check(s_ch == 2, "R10", "channel granted", s_ch, 2);
        step();
        unit_done = 1; block_done = 1; hblank = 1;
        step();
        quiet(8, "R10");
        hblank = 1; wait_grant(n);
        check(s_grant && s_ch == 2, "R10", "later strobe still arms", s_grant, 1);
        step();
        unit_done = 1; block_done = 1;
        step(); step();
        auto_eng = 1;
        clear_all();

        // R11 disable drops pending
        cur_req = "R11";
        set_mode(1, 2); en_r = 4'b0010; step();
        hblank = 1; step();
        en_r[1] = 0;
        quiet(8, "R11");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule